// File: doc/BRIEF.md
# Fully Associative Address Translation Buffer with Address-Space Tags

This block caches recent virtual-to-physical page translations. It compares a lookup against every stored entry at the same time and returns a physical address in the same cycle. Each entry is tagged with an address space number (ASN), so the translations of several processes can be held together without a flush on a context switch. Every hit is also checked against permission bits stored with the entry.

Surrounding logic installs translations through a fill port, normally after it has walked the page table on a miss. The same logic removes translations through an invalidate port. A fill goes to the slot chosen by a round-robin pointer. If an entry with the same page and ASN already exists, the fill overwrites that entry instead, so the array never holds a duplicate. Invalidation can clear one translation, every translation of one ASN, or the whole array.

Top module: `fa_tlb`

## Requirements
- R1: After reset every entry is invalid, so every lookup reports no hit, no fault and a physical address of zero.
- R2: The lookup address splits into page number `lk_vaddr[47:13]` and offset `lk_vaddr[12:0]`. A lookup matches only a valid entry whose page tag equals the page number and whose ASN equals `lk_asn`. The same page under a different ASN does not match.
- R3: The lookup is combinational. On a match `lk_paddr` is `{PPN, offset}` within the same cycle. With no match it is zero.
- R4: Permission bits of an entry: bit 0 allows user read, bit 1 user write, bit 2 kernel read, bit 3 kernel write. The bit checked is selected by `{lk_kernel, lk_write}`. A match on a permitted access raises `lk_hit` only. A match on a forbidden access raises `lk_fault` only and still drives the translated address.
- R5: A fill whose page and ASN match no valid entry writes the slot under the round-robin pointer. The pointer then advances, wrapping from 127 to 0, so the 129th distinct fill after reset replaces the first.
- R6: A fill whose page and ASN match a valid entry overwrites that entry in place and leaves the pointer where it is.
- R7: Invalidate op 1 clears only the entry matching `iv_vpn` and `iv_asn`.
- R8: Invalidate op 2 clears every entry whose ASN is `iv_asn` and leaves other ASNs intact.
- R9: Invalidate op 3 clears all entries.
- R10: A fill presented in the same cycle as any invalidate op (nonzero `iv_op`) is dropped.
- R11: At most one entry matches any lookup. Removing a translation once removes it completely.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lk_vaddr | input | 48 | Lookup virtual address |
| lk_asn | input | 8 | ASN of the current process |
| lk_write | input | 1 | 1 = write access, 0 = read |
| lk_kernel | input | 1 | 1 = kernel mode, 0 = user |
| lk_hit | output | 1 | Permitted match |
| lk_fault | output | 1 | Match with forbidden access |
| lk_paddr | output | 44 | Translated physical address |
| fl_en | input | 1 | Install a translation at the next edge |
| fl_vpn | input | 35 | Page number to install |
| fl_asn | input | 8 | ASN to install |
| fl_ppn | input | 31 | Physical page number to install |
| fl_prot | input | 4 | Permission bits to install |
| iv_op | input | 2 | 0 none, 1 single, 2 by ASN, 3 all |
| iv_vpn | input | 35 | Page number for single invalidate |
| iv_asn | input | 8 | ASN for single and by-ASN invalidate |

## Verification
Lookup results are due in the cycle the lookup address is applied. No register lies between the lookup inputs and the hit, fault and address outputs, so the bench drives a lookup just after a falling edge and samples 2 ns later, well before the next rising edge. Fills and invalidates take effect at the first rising edge after they are driven. The bench holds them through exactly that one edge and issues follow-up lookups only after it. Replacement is checked by filling all 128 slots and then watching which translation the next new fill displaces.

// File: rtl/tlb_pkg.sv
package tlb_pkg;

  localparam int PROT_W = 4;

  typedef enum logic [1:0] {
    INV_NONE = 2'd0,
    INV_ONE  = 2'd1,
    INV_ASN  = 2'd2,
    INV_ALL  = 2'd3
  } inv_op_e;

  // Permission index is {kernel, write}: 0 user rd, 1 user wr, 2 kern rd, 3 kern wr
  function automatic logic prot_allows(input logic [PROT_W-1:0] prot,
                                       input logic is_write,
                                       input logic is_kernel);
    logic [1:0] sel;
    sel = {is_kernel, is_write};
    return prot[sel];
  endfunction

endpackage

// File: rtl/tlb_entry_store.sv
module tlb_entry_store
  import tlb_pkg::*;
#(
  parameter int ENTRIES = 128,
  parameter int VPN_W   = 35,
  parameter int ASN_W   = 8,
  parameter int PPN_W   = 31,
  parameter int IDX_W   = $clog2(ENTRIES)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_en,
  input  logic [IDX_W-1:0]    wr_idx,
  input  logic [VPN_W-1:0]    wr_vpn,
  input  logic [ASN_W-1:0]    wr_asn,
  input  logic [PPN_W-1:0]    wr_ppn,
  input  logic [PROT_W-1:0]   wr_prot,
  input  logic [ENTRIES-1:0]  clr_mask,
  input  logic [VPN_W-1:0]    lk_vpn,
  input  logic [ASN_W-1:0]    lk_asn,
  input  logic [VPN_W-1:0]    mt_vpn,
  input  logic [ASN_W-1:0]    mt_asn,
  output logic [ENTRIES-1:0]  lk_match,
  output logic [ENTRIES-1:0]  mt_match,
  output logic [ENTRIES-1:0]  asn_match,
  output logic [ENTRIES-1:0]  valid_q,
  output logic [PPN_W-1:0]    ppn_arr  [ENTRIES],
  output logic [PROT_W-1:0]   prot_arr [ENTRIES]
);

  for (genvar e = 0; e < ENTRIES; e++) begin : g_ent
    logic              v_q;
    logic [VPN_W-1:0]  vpn_q;
    logic [ASN_W-1:0]  asn_q;
    logic [PPN_W-1:0]  ppn_q;
    logic [PROT_W-1:0] prot_q;
    logic              wr_here;

    assign wr_here = wr_en && (wr_idx == IDX_W'(e));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)           v_q <= 1'b0;
      else if (wr_here)     v_q <= 1'b1;
      else if (clr_mask[e]) v_q <= 1'b0;
    end

    always_ff @(posedge clk) begin
      if (wr_here) begin
        vpn_q  <= wr_vpn;
        asn_q  <= wr_asn;
        ppn_q  <= wr_ppn;
        prot_q <= wr_prot;
      end
    end

    assign valid_q[e]   = v_q;
    assign lk_match[e]  = v_q && (vpn_q == lk_vpn) && (asn_q == lk_asn);
    assign mt_match[e]  = v_q && (vpn_q == mt_vpn) && (asn_q == mt_asn);
    assign asn_match[e] = v_q && (asn_q == mt_asn);
    assign ppn_arr[e]   = ppn_q;
    assign prot_arr[e]  = prot_q;
  end

  AST_ONE_LOOKUP_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(lk_match)); // R11

  AST_NO_DUP_KEY: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(mt_match)); // R6

endmodule

// File: rtl/tlb_sel_mux.sv
module tlb_sel_mux
  import tlb_pkg::*;
#(
  parameter int ENTRIES = 128,
  parameter int PPN_W   = 31
) (
  input  logic [ENTRIES-1:0] sel,
  input  logic [PPN_W-1:0]   ppn_arr  [ENTRIES],
  input  logic [PROT_W-1:0]  prot_arr [ENTRIES],
  output logic               any,
  output logic [PPN_W-1:0]   ppn,
  output logic [PROT_W-1:0]  prot
);

  // AND-OR select: valid because at most one select bit is set
  always_comb begin
    ppn  = '0;
    prot = '0;
    for (int e = 0; e < ENTRIES; e++) begin
      ppn  = ppn  | (ppn_arr[e]  & {PPN_W{sel[e]}});
      prot = prot | (prot_arr[e] & {PROT_W{sel[e]}});
    end
    any = |sel;
  end

endmodule

// File: rtl/tlb_repl_ctrl.sv
module tlb_repl_ctrl #(
  parameter int ENTRIES = 128,
  parameter int IDX_W   = $clog2(ENTRIES)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               fill_go,
  input  logic [ENTRIES-1:0] hit_vec,
  output logic               wr_en,
  output logic [IDX_W-1:0]   wr_idx
);

  localparam logic [IDX_W-1:0] LAST = IDX_W'(ENTRIES - 1);

  function automatic logic [IDX_W-1:0] encode(input logic [ENTRIES-1:0] v);
    logic [IDX_W-1:0] r;
    r = '0;
    for (int e = 0; e < ENTRIES; e++)
      if (v[e]) r = r | IDX_W'(e);
    return r;
  endfunction

  function automatic logic [IDX_W-1:0] step(input logic [IDX_W-1:0] p);
    return (p == LAST) ? '0 : p + 1'b1;
  endfunction

  logic [IDX_W-1:0] ptr_q;
  logic             exist;
  logic             new_slot;

  assign exist    = |hit_vec;
  assign new_slot = fill_go && !exist;
  assign wr_en    = fill_go;
  assign wr_idx   = exist ? encode(hit_vec) : ptr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        ptr_q <= '0;
    else if (new_slot) ptr_q <= step(ptr_q);
  end

  AST_RR_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_go && !exist) |=> (ptr_q == (($past(ptr_q) == LAST) ? '0 : $past(ptr_q) + 1'b1))); // R5

  AST_RR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!fill_go || exist) |=> $stable(ptr_q)); // R6

endmodule

// File: rtl/fa_tlb.sv
module fa_tlb
  import tlb_pkg::*;
#(
  parameter int ENTRIES = 128,
  parameter int VPN_W   = 35,
  parameter int OFF_W   = 13,
  parameter int ASN_W   = 8,
  parameter int PPN_W   = 31
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [VPN_W+OFF_W-1:0] lk_vaddr,
  input  logic [ASN_W-1:0]       lk_asn,
  input  logic                   lk_write,
  input  logic                   lk_kernel,
  output logic                   lk_hit,
  output logic                   lk_fault,
  output logic [PPN_W+OFF_W-1:0] lk_paddr,
  input  logic                   fl_en,
  input  logic [VPN_W-1:0]       fl_vpn,
  input  logic [ASN_W-1:0]       fl_asn,
  input  logic [PPN_W-1:0]       fl_ppn,
  input  logic [3:0]             fl_prot,
  input  logic [1:0]             iv_op,
  input  logic [VPN_W-1:0]       iv_vpn,
  input  logic [ASN_W-1:0]       iv_asn
);

  localparam int VA_W  = VPN_W + OFF_W;
  localparam int PA_W  = PPN_W + OFF_W;
  localparam int IDX_W = $clog2(ENTRIES);

  logic [VPN_W-1:0]  lk_vpn;
  logic [OFF_W-1:0]  lk_off;
  logic [VPN_W-1:0]  mt_vpn;
  logic [ASN_W-1:0]  mt_asn;
  logic              inv_busy;
  logic              fill_go;
  logic [ENTRIES-1:0] lk_match, mt_match, asn_match, valid_q, clr_mask;
  logic [PPN_W-1:0]  ppn_arr  [ENTRIES];
  logic [PROT_W-1:0] prot_arr [ENTRIES];
  logic              wr_en;
  logic [IDX_W-1:0]  wr_idx;
  logic              sel_any;
  logic [PPN_W-1:0]  sel_ppn;
  logic [PROT_W-1:0] sel_prot;
  logic              allowed;
  inv_op_e           op;

  assign lk_vpn   = lk_vaddr[VA_W-1:OFF_W];
  assign lk_off   = lk_vaddr[OFF_W-1:0];
  assign op       = inv_op_e'(iv_op);
  assign inv_busy = (op != INV_NONE);
  assign fill_go  = fl_en && !inv_busy;
  // One maintenance compare port, shared by fill and invalidate (never both)
  assign mt_vpn   = inv_busy ? iv_vpn : fl_vpn;
  assign mt_asn   = inv_busy ? iv_asn : fl_asn;

  always_comb begin
    unique case (op)
      INV_ONE:  clr_mask = mt_match;
      INV_ASN:  clr_mask = asn_match;
      INV_ALL:  clr_mask = '1;
      default:  clr_mask = '0;
    endcase
  end

  tlb_entry_store #(
    .ENTRIES(ENTRIES), .VPN_W(VPN_W), .ASN_W(ASN_W), .PPN_W(PPN_W), .IDX_W(IDX_W)
  ) u_store (
    .clk(clk), .rst_n(rst_n),
    .wr_en(wr_en), .wr_idx(wr_idx),
    .wr_vpn(fl_vpn), .wr_asn(fl_asn), .wr_ppn(fl_ppn), .wr_prot(fl_prot),
    .clr_mask(clr_mask),
    .lk_vpn(lk_vpn), .lk_asn(lk_asn),
    .mt_vpn(mt_vpn), .mt_asn(mt_asn),
    .lk_match(lk_match), .mt_match(mt_match), .asn_match(asn_match),
    .valid_q(valid_q), .ppn_arr(ppn_arr), .prot_arr(prot_arr)
  );

  tlb_repl_ctrl #(.ENTRIES(ENTRIES), .IDX_W(IDX_W)) u_repl (
    .clk(clk), .rst_n(rst_n),
    .fill_go(fill_go), .hit_vec(mt_match),
    .wr_en(wr_en), .wr_idx(wr_idx)
  );

  tlb_sel_mux #(.ENTRIES(ENTRIES), .PPN_W(PPN_W)) u_mux (
    .sel(lk_match), .ppn_arr(ppn_arr), .prot_arr(prot_arr),
    .any(sel_any), .ppn(sel_ppn), .prot(sel_prot)
  );

  assign allowed  = prot_allows(sel_prot, lk_write, lk_kernel);
  assign lk_hit   = sel_any && allowed;
  assign lk_fault = sel_any && !allowed;
  assign lk_paddr = sel_any ? {sel_ppn, lk_off} : {PA_W{1'b0}};

  AST_HIT_FAULT_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(lk_hit && lk_fault)); // R4

  AST_MISS_ZERO_PA: assert property (@(posedge clk) disable iff (!rst_n)
    !(lk_hit || lk_fault) |-> (lk_paddr == '0)); // R3

  AST_INV_ALL_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    (iv_op == 2'd3) |=> (valid_q == '0)); // R9

  AST_INV_DROPS_FILL: assert property (@(posedge clk) disable iff (!rst_n)
    (iv_op != 2'd0) |-> !wr_en); // R10

endmodule

// File: tb/fa_tlb_bench.sv
`timescale 1ns/1ps
module fa_tlb_bench;

  localparam int VPN_W = 35, OFF_W = 13, ASN_W = 8, PPN_W = 31;
  localparam logic [2:0] K_LOOK = 3'd0, K_FILL = 3'd1, K_INV1 = 3'd2,
                         K_INVA = 3'd3, K_FALL = 3'd4;
  localparam logic [VPN_W-1:0] VA = 35'h0_0000_1234, VB = 35'h7_FFFF_FFFF,
                               VC = 35'h0_0000_0042, VD = 35'h1_2345_6789;

  typedef struct packed {
    logic [2:0]       kind;
    logic [3:0]       req;
    logic [VPN_W-1:0] vpn;
    logic [ASN_W-1:0] asn;
    logic [PPN_W-1:0] ppn;
    logic [3:0]       prot;
    logic             wr;
    logic             kern;
    logic             eh;
    logic             ef;
    logic [PPN_W-1:0] eppn;
  } vec_t;

  localparam int NV = 28;
  localparam vec_t VEC [NV] = '{
    '{K_FILL, 4'd5,  VA,      8'd5, 31'h0ABCDE,   4'hF, 1'b0, 1'b0, 1'b0, 1'b0, 31'h0},
    '{K_LOOK, 4'd3,  VA,      8'd5, 31'h0,        4'h0, 1'b0, 1'b0, 1'b1, 1'b0, 31'h0ABCDE},  // R3
    '{K_LOOK, 4'd2,  VA,      8'd6, 31'h0,        4'h0, 1'b0, 1'b0, 1'b0, 1'b0, 31'h0},       // R2 asn differs
    '{K_LOOK, 4'd2,  VA + 35'd1, 8'd5, 31'h0,     4'h0, 1'b0, 1'b0, 1'b0, 1'b0, 31'h0},       // R2 vpn differs
    '{K_FILL, 4'd4,  VB,      8'd5, 31'h7FFFFFFF, 4'h5, 1'b0, 1'b0, 1'b0, 1'b0, 31'h0},
    '{K_LOOK, 4'd4,  VB,      8'd5, 31'h0,        4'h0, 1'b0, 1'b0, 1'b1, 1'b0, 31'h7FFFFFFF}, // R4 user rd
    '{K_LOOK, 4'd4,  VB,      8'd5, 31'h0,        4'h0, 1'b1, 1'b0, 1'b0, 1'b1, 31'h7FFFFFFF}, // R4 user wr
    '{K_LOOK, 4'd4,  VB,      8'd5, 31'h0,        4'h0, 1'b1, 1'b1, 1'b0, 1'b1, 31'h7FFFFFFF}, // R4 kern wr
    '{K_LOOK, 4'd4,  VB,      8'd5, 31'h0,        4'h0, 1'b0, 1'b1, 1'b1, 1'b0, 31'h7FFFFFFF}, // R4 kern rd
    '{K_FILL, 4'd4,  VC,      8'd9, 31'h0000123,  4'hC, 1'b0, 1'b0, 1'b0, 1'b0, 31'h0},
    '{K_LOOK, 4'd4,  VC,      8'd9, 31'h0,        4'h0, 1'b0, 1'b0, 1'b0, 1'b1, 31'h0000123},  // R4
    '{K_LOOK, 4'd4,  VC,      8'd9, 31'h0,        4'h0, 1'b1, 1'b1, 1'b1, 1'b0, 31'h0000123},  // R4
    '{K_FILL, 4'd2,  VA,      8'd6, 31'h0000111,  4'hF, 1'b0, 1'b0, 1'b0, 1'b0, 31'h0},
    '{K_LOOK, 4'd2,  VA,      8'd6, 31'h0,        4'h0, 1'b0, 1'b0, 1'b1, 1'b0, 31'h0000111},  // R2
    '{K_LOOK, 4'd2,  VA,      8'd5, 31'h0,        4'h0, 1'b0, 1'b0, 1'b1, 1'b0, 31'h0ABCDE},   // R2
    '{K_FILL, 4'd6,  VA,      8'd5, 31'h0000222,  4'hF, 1'b0, 1'b0, 1'b0, 1'b0, 31'h0},
    '{K_LOOK, 4'd6,  VA,      8'd5, 31'h0,        4'h0, 1'b0, 1'b0, 1'b1, 1'b0, 31'h0000222},  // R6
    '{K_INV1, 4'd7,  VA,      8'd5, 31'h0,        4'h0, 1'b0, 1'b0, 1'b0, 1'b0, 31'h0},
    '{K_LOOK, 4'd7,  VA,      8'd5, 31'h0,        4'h0, 1'b0, 1'b0, 1'b0, 1'b0, 31'h0},        // R7
    '{K_LOOK, 4'd7,  VA,      8'd6, 31'h0,        4'h0, 1'b0, 1'b0, 1'b1, 1'b0, 31'h0000111},  // R7
    '{K_INVA, 4'd8,  VD,      8'd5, 31'h0,        4'h0, 1'b0, 1'b0, 1'b0, 1'b0, 31'h0},
    '{K_LOOK, 4'd8,  VB,      8'd5, 31'h0,        4'h0, 1'b0, 1'b0, 1'b0, 1'b0, 31'h0},        // R8
    '{K_LOOK, 4'd8,  VC,      8'd9, 31'h0,        4'h0, 1'b1, 1'b1, 1'b1, 1'b0, 31'h0000123},  // R8
    '{K_LOOK, 4'd8,  VA,      8'd6, 31'h0,        4'h0, 1'b0, 1'b0, 1'b1, 1'b0, 31'h0000111},  // R8
    '{K_FALL, 4'd10, VD,      8'd3, 31'h0000333,  4'hF, 1'b0, 1'b0, 1'b0, 1'b0, 31'h0},
    '{K_LOOK, 4'd10, VD,      8'd3, 31'h0,        4'h0, 1'b0, 1'b0, 1'b0, 1'b0, 31'h0},        // R10
    '{K_LOOK, 4'd9,  VC,      8'd9, 31'h0,        4'h0, 1'b1, 1'b1, 1'b0, 1'b0, 31'h0},        // R9
    '{K_LOOK, 4'd9,  VA,      8'd6, 31'h0,        4'h0, 1'b0, 1'b0, 1'b0, 1'b0, 31'h0}         // R9
  };

  logic clk = 1'b0;
  logic rst_n;
  logic [VPN_W+OFF_W-1:0] lk_vaddr;
  logic [ASN_W-1:0] lk_asn;
  logic lk_write, lk_kernel, lk_hit, lk_fault;
  logic [PPN_W+OFF_W-1:0] lk_paddr;
  logic fl_en;
  logic [VPN_W-1:0] fl_vpn, iv_vpn;
  logic [ASN_W-1:0] fl_asn, iv_asn;
  logic [PPN_W-1:0] fl_ppn;
  logic [3:0] fl_prot;
  logic [1:0] iv_op;

  int n_vec = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  fa_tlb u_fa_tlb (
    .clk(clk), .rst_n(rst_n),
    .lk_vaddr(lk_vaddr), .lk_asn(lk_asn), .lk_write(lk_write), .lk_kernel(lk_kernel),
    .lk_hit(lk_hit), .lk_fault(lk_fault), .lk_paddr(lk_paddr),
    .fl_en(fl_en), .fl_vpn(fl_vpn), .fl_asn(fl_asn), .fl_ppn(fl_ppn), .fl_prot(fl_prot),
    .iv_op(iv_op), .iv_vpn(iv_vpn), .iv_asn(iv_asn)
  );

  task automatic look(input logic [VPN_W-1:0] vpn, input logic [ASN_W-1:0] asn,
                      input logic wr, input logic kern, input logic eh, input logic ef,
                      input logic [PPN_W-1:0] eppn, input int req);
    logic [OFF_W-1:0] off;
    logic [PPN_W+OFF_W-1:0] epa;
    off = vpn[OFF_W-1:0] ^ 13'h0A5;
    lk_vaddr = {vpn, off}; lk_asn = asn; lk_write = wr; lk_kernel = kern;
    epa = (eh || ef) ? {eppn, off} : '0;
    #2;
    n_vec++;
    if (lk_hit !== eh || lk_fault !== ef || lk_paddr !== epa) begin
      n_bad++;
      $display("FAIL R%0d: hit=%0b fault=%0b pa=%h, expected hit=%0b fault=%0b pa=%h",
               req, lk_hit, lk_fault, lk_paddr, eh, ef, epa);
    end
    @(negedge clk);
  endtask

  task automatic fill(input logic [VPN_W-1:0] vpn, input logic [ASN_W-1:0] asn,
                      input logic [PPN_W-1:0] ppn, input logic [3:0] prot,
                      input logic [1:0] op);
    fl_vpn = vpn; fl_asn = asn; fl_ppn = ppn; fl_prot = prot; fl_en = 1'b1;
    iv_op = op; iv_vpn = vpn; iv_asn = asn;
    @(negedge clk);
    fl_en = 1'b0; iv_op = 2'd0;
  endtask

  task automatic inval(input logic [1:0] op, input logic [VPN_W-1:0] vpn,
                       input logic [ASN_W-1:0] asn);
    iv_op = op; iv_vpn = vpn; iv_asn = asn;
    @(negedge clk);
    iv_op = 2'd0;
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; fl_en = 1'b0; iv_op = 2'd0;
    lk_vaddr = '0; lk_asn = '0; lk_write = 1'b0; lk_kernel = 1'b0;
    fl_vpn = '0; fl_asn = '0; fl_ppn = '0; fl_prot = '0; iv_vpn = '0; iv_asn = '0;
    @(negedge clk);
    do_reset();

    // R1: empty after reset
    look(VA, 8'd5, 1'b0, 1'b0, 1'b0, 1'b0, '0, 1);
    look(VB, 8'd0, 1'b1, 1'b1, 1'b0, 1'b0, '0, 1);

    for (int i = 0; i < NV; i++) begin
      case (VEC[i].kind)
        K_LOOK: look(VEC[i].vpn, VEC[i].asn, VEC[i].wr, VEC[i].kern,
                     VEC[i].eh, VEC[i].ef, VEC[i].eppn, int'(VEC[i].req));
        K_FILL: fill(VEC[i].vpn, VEC[i].asn, VEC[i].ppn, VEC[i].prot, 2'd0);
        K_INV1: inval(2'd1, VEC[i].vpn, VEC[i].asn);
        K_INVA: inval(2'd2, VEC[i].vpn, VEC[i].asn);
        default: fill(VEC[i].vpn, VEC[i].asn, VEC[i].ppn, VEC[i].prot, 2'd3);
      endcase
    end

    // R5: fill every slot from a reset pointer, then one overwrite and one new fill
    do_reset();
    for (int i = 0; i < 128; i++)
      fill(35'h100 + 35'(i), 8'd1, 31'h1000 + 31'(i), 4'hF, 2'd0);
    look(35'h100, 8'd1, 1'b0, 1'b0, 1'b1, 1'b0, 31'h1000, 5);
    fill(35'h105, 8'd1, 31'h55, 4'hF, 2'd0);   // R6 overwrite, pointer stays at 0
    fill(35'h999, 8'd1, 31'h999, 4'hF, 2'd0);  // R5 evicts slot 0
    look(35'h100, 8'd1, 1'b0, 1'b0, 1'b0, 1'b0, '0, 5);
    look(35'h101, 8'd1, 1'b0, 1'b0, 1'b1, 1'b0, 31'h1001, 6);
    look(35'h999, 8'd1, 1'b0, 1'b0, 1'b1, 1'b0, 31'h999, 5);
    look(35'h105, 8'd1, 1'b0, 1'b0, 1'b1, 1'b0, 31'h55, 6);
    look(35'h17F, 8'd1, 1'b0, 1'b0, 1'b1, 1'b0, 31'h107F, 5);
    // R11: no duplicate left behind by the overwrite
    inval(2'd1, 35'h105, 8'd1);
    look(35'h105, 8'd1, 1'b0, 1'b0, 1'b0, 1'b0, '0, 11);

    // R1: reset clears a full array
    do_reset();
    look(35'h101, 8'd1, 1'b0, 1'b0, 1'b0, 1'b0, '0, 1);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

endmodule